// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory

This block is a word-addressed memory split into a power-of-two number of banks. Each bank has its own address, can run an access at the same time as the others and, once started, stays busy for a fixed number of clocks. A vector load/store unit offers one element request per clock. Consecutive word addresses fall in consecutive banks, so a stream that walks the banks in turn can keep every bank working while earlier accesses are still completing.

When a request targets a bank that is still busy, the block lowers its ready signal and the requester holds the request until the bank frees. Reads return their data a fixed number of clocks after acceptance. Because every access has the same latency, responses leave in exactly the order the reads were accepted. Writes update the bank and return no response.

Two effects appear at the edge of the block and follow directly from bank occupancy. Short unit-stride streams stall when there are fewer banks than clocks of latency. Strides that keep landing on one bank are throttled to one element per latency period.

Top module: `interleaved_bank_mem`

## Requirements
- R1: A word address selects bank `addr mod NUM_BANKS` (the low address bits) and row `addr / NUM_BANKS` within that bank. Addresses that differ by a multiple of NUM_BANKS share a bank.
- R2: A read accepted in cycle c (req_valid and req_ready both high) drives rsp_valid high in cycle c+LATENCY, with rsp_data equal to the word at that address. There is one response per accepted read, and responses come in acceptance order.
- R3: A bank that accepted a request in cycle c is busy through cycle c+LATENCY-1 and free again in cycle c+LATENCY. req_ready is low exactly while the addressed bank is busy, and no request is accepted while req_ready is low.
- R4: Requests to distinct free banks are accepted one per clock with no stall, and at most one bank starts an access in any cycle.
- R5: With NUM_BANKS >= LATENCY, a unit-stride read stream is accepted one element per clock and returns one word per clock, starting LATENCY cycles after the first request.
- R6: A write (req_write=1) stores req_wdata at its address, occupies the bank like a read and produces no response. A later read of that address returns the written value.
- R7: A stride that maps every element to the same bank (for example a stride equal to NUM_BANKS) is accepted only once every LATENCY cycles.
- R8: During reset rsp_valid is low and every bank is free, so req_ready is high.
- R9: With NUM_BANKS < LATENCY, a unit-stride stream is accepted in groups of NUM_BANKS back-to-back elements spaced LATENCY cycles apart. The response stream has the same gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Addressed bank is free; request accepted when valid is also high |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data returned this cycle |
| rsp_data | output | DATA_W | Read data |

## Verification
Read streams are driven at several strides and the bench predicts, for every element, the cycle it should be accepted and returned. Unit stride and an odd stride reach every bank and should never stall. A stride of two reaches exactly LATENCY banks and should just avoid stalling. Strides of four, NUM_BANKS and twice NUM_BANKS fold onto one or two banks, which separates a correct bank-busy window from one that is a cycle too long or too short. A second instance with fewer banks than clocks of latency shows the grouped gaps, and directed probes of req_ready around the last busy cycle, together with an overwrite-and-readback, pin down the busy boundary and the row mapping.

// File: rtl/ibm_pkg.sv
package ibm_pkg;

  // Bank index of a word address: low bits when the bank count is a power of two.
  function automatic int unsigned pick_bank(input int unsigned addr, input int unsigned banks);
    return addr % banks;
  endfunction

  // Row inside the selected bank: remaining upper address bits.
  function automatic int unsigned pick_row(input int unsigned addr, input int unsigned banks);
    return addr / banks;
  endfunction

endpackage

// File: rtl/ibm_bank.sv
module ibm_bank #(
  parameter int ROW_W   = 7,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              free,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(LATENCY - 1);

  logic [DATA_W-1:0] store [ROWS];
  logic [CNT_W-1:0]  busy_cnt;

  assign free = (busy_cnt == '0);

  // Occupancy: the starting cycle plus LATENCY-1 more cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (start)
      busy_cnt <= BUSY_LOAD;
    else if (busy_cnt != '0)
      busy_cnt <= busy_cnt - 1'b1;
  end

  // Array access happens at start; read data is held while the bank is busy.
  always_ff @(posedge clk) begin
    if (start) begin
      if (wr)
        store[row] <= wdata;
      else
        rdata <= store[row];
    end
  end

  assert_start_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> free);

  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && LATENCY > 1) |=> !free);

endmodule

// File: rtl/ibm_resp_queue.sv
module ibm_resp_queue #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  output logic             out_vld,
  output logic [IDX_W-1:0] out_idx
);
  // One slot per clock of latency; every entry ages at the same rate,
  // so request order is kept without any reordering logic.
  logic             slot_vld [DEPTH];
  logic [IDX_W-1:0] slot_idx [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) slot_vld[0] <= 1'b0;
    else        slot_vld[0] <= push;
    slot_idx[0] <= push_idx;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) slot_vld[s] <= 1'b0;
      else        slot_vld[s] <= slot_vld[s-1];
      slot_idx[s] <= slot_idx[s-1];
    end
  end

  assign out_vld = slot_vld[DEPTH-1];
  assign out_idx = slot_idx[DEPTH-1];

endmodule

// File: rtl/interleaved_bank_mem.sv
module interleaved_bank_mem #(
  parameter int NUM_BANKS = 8,
  parameter int LATENCY   = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import ibm_pkg::*;

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ROW_W  = ADDR_W - $clog2(NUM_BANKS);

  logic [BANK_W-1:0] bank_sel;
  logic [ROW_W-1:0]  row_sel;
  logic              accept;
  logic [NUM_BANKS-1:0] bank_start;
  logic [NUM_BANKS-1:0] bank_free;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
  logic              q_vld;
  logic [BANK_W-1:0] q_idx;

  assign bank_sel  = BANK_W'(pick_bank(32'(req_addr), NUM_BANKS));
  assign row_sel   = ROW_W'(pick_row(32'(req_addr), NUM_BANKS));
  assign req_ready = bank_free[bank_sel];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_start[b] = accept && (bank_sel == BANK_W'(b));

    ibm_bank #(
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W),
      .LATENCY(LATENCY)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bank_start[b]),
      .wr    (req_write),
      .row   (row_sel),
      .wdata (req_wdata),
      .free  (bank_free[b]),
      .rdata (bank_rdata[b])
    );
  end

  ibm_resp_queue #(
    .DEPTH(LATENCY),
    .IDX_W(BANK_W)
  ) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept && !req_write),
    .push_idx(bank_sel),
    .out_vld (q_vld),
    .out_idx (q_idx)
  );

  assign rsp_valid = q_vld;
  assign rsp_data  = bank_rdata[q_idx];

  assert_one_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_start));

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (bank_start == '0));

endmodule

// File: tb/interleaved_bank_mem_test.sv
module interleaved_bank_mem_test;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NB = 8;
  localparam int NB_N = 2;
  localparam int LAT = 4;
  localparam int WORDS = 1 << AW;

  // Stream table: base, stride, length.
  localparam int TB_ROWS = 6;
  localparam int TB_BASE   [TB_ROWS] = '{0, 3, 100, 1, 7, 2};
  localparam int TB_STRIDE [TB_ROWS] = '{1, 8, 2, 4, 3, 16};
  localparam int TB_LEN    [TB_ROWS] = '{16, 5, 12, 8, 10, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          valid = 1'b0;
  logic          sel = 1'b0;
  logic          ready0, ready1, rv0, rv1;
  logic [DW-1:0] rd0, rd1;

  interleaved_bank_mem #(.NUM_BANKS(NB), .LATENCY(LAT), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(valid && !sel), .req_ready(ready0),
    .req_addr(addr), .req_write(wr), .req_wdata(wdata),
    .rsp_valid(rv0), .rsp_data(rd0));

  interleaved_bank_mem #(.NUM_BANKS(NB_N), .LATENCY(LAT), .ADDR_W(AW), .DATA_W(DW)) u_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(valid && sel), .req_ready(ready1),
    .req_addr(addr), .req_write(wr), .req_wdata(wdata),
    .rsp_valid(rv1), .rsp_data(rd1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int ovr_addr = -1;
  int ovr_val = 0;

  int rsp_cyc [64];
  int rsp_dat [64];
  int rsp_n = 0;

  always @(negedge clk) begin
    if ((sel ? rv1 : rv0) && rsp_n < 64) begin
      rsp_cyc[rsp_n] = cyc;
      rsp_dat[rsp_n] = int'(sel ? rd1 : rd0);
      rsp_n = rsp_n + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int fill(input int a);
    if (a == ovr_addr) return ovr_val;
    return (a * 37 + 11) & 16'hFFFF;
  endfunction

  function automatic logic cur_ready();
    return sel ? ready1 : ready0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preload(input logic s, input int count);
    sel = s;
    @(negedge clk);
    for (int a = 0; a < count; a++) begin
      addr = AW'(a); wr = 1'b1; wdata = DW'(fill(a)); valid = 1'b1;
      #1;
      while (!cur_ready()) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    valid = 1'b0; wr = 1'b0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  // Drive a stream, then compare accept/response cycles and data with a bank-occupancy model.
  task automatic run_stream(input logic s, input int base, input int stride, input int n,
                            input logic w, input string tag);
    int acc [64];
    int adr [64];
    int free_at [NB];
    int banks;
    int start;
    int prev;
    banks = s ? NB_N : NB;
    sel = s;
    @(negedge clk);
    rsp_n = 0;
    start = cyc;
    for (int i = 0; i < n; i++) begin
      adr[i] = (base + i * stride) % WORDS;
      addr = AW'(adr[i]); wr = w; wdata = DW'(fill(adr[i])); valid = 1'b1;
      #1;
      while (!cur_ready()) begin @(negedge clk); #1; end
      acc[i] = cyc;
      @(negedge clk);
    end
    valid = 1'b0; wr = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    for (int b = 0; b < NB; b++) free_at[b] = 0;
    prev = start - 1;
    for (int i = 0; i < n; i++) begin
      int b;
      int e;
      b = adr[i] % banks;
      e = prev + 1;
      if (free_at[b] > e) e = free_at[b];
      free_at[b] = e + LAT;
      prev = e;
      check(acc[i] == e, {"R1/R3 accept cycle ", tag}, acc[i] - start, e - start);
    end
    if (w) begin
      check(rsp_n == 0, "R6 write gives no response", rsp_n, 0);
    end else begin
      check(rsp_n == n, {"R2 response count ", tag}, rsp_n, n);
      for (int k = 0; k < n && k < rsp_n; k++) begin
        check(rsp_cyc[k] == acc[k] + LAT, {"R2 response cycle ", tag}, rsp_cyc[k] - acc[k], LAT);
        check(rsp_dat[k] == fill(adr[k]), {"R1/R2 response data ", tag}, rsp_dat[k], fill(adr[k]));
      end
    end
  endtask

  function automatic string row_tag(input int r);
    case (r)
      0: return "R5 unit stride";
      1: return "R7 stride equals bank count";
      2: return "R4 stride two";
      3: return "R7 stride four two banks";
      4: return "R4 odd stride";
      default: return "R7 stride twice bank count";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(ready0 == 1'b1, "R8 ready during reset", int'(ready0), 1);
    check(rv0 == 1'b0, "R8 rsp_valid during reset", int'(rv0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    preload(1'b0, WORDS);
    preload(1'b1, 64);

    for (int r = 0; r < TB_ROWS; r++)
      run_stream(1'b0, TB_BASE[r], TB_STRIDE[r], TB_LEN[r], 1'b0, row_tag(r));

    // R9: fewer banks than clocks of latency
    run_stream(1'b1, 0, 1, 8, 1'b0, "R9 grouped gaps");

    // Directed busy-window probes, R3 and R4
    sel = 1'b0;
    @(negedge clk);
    addr = AW'(0); wr = 1'b0; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    addr = AW'(8);  #1 check(ready0 == 1'b0, "R3 same bank busy next cycle", int'(ready0), 0);
    addr = AW'(16); #1 check(ready0 == 1'b0, "R1 address 16 maps to bank 0", int'(ready0), 0);
    addr = AW'(9);  #1 check(ready0 == 1'b1, "R4 other bank free", int'(ready0), 1);
    repeat (LAT - 2) @(negedge clk);
    addr = AW'(8);  #1 check(ready0 == 1'b0, "R3 busy in last cycle", int'(ready0), 0);
    @(negedge clk);
    #1 check(ready0 == 1'b1, "R3 free after LATENCY cycles", int'(ready0), 1);
    repeat (LAT + 2) @(negedge clk);

    // R6 overwrite then readback of the same bank's neighbouring rows
    ovr_addr = 5; ovr_val = 16'h1234;
    run_stream(1'b0, 5, 1, 1, 1'b1, "R6 overwrite");
    run_stream(1'b0, 5, 8, 3, 1'b0, "R6 readback");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule